// File: doc/BRIEF.md
# Dual-Channel Drive Switchover Arbiter

This block decides which of two redundant motor drive channels, A or B, may enable its power bridge, and it steers the position-sensor input to follow the channel in charge. A switchover request carries a cause code. On an accepted request the block removes the enable of the running channel and holds both enables low for a programmable break interval. It then moves the sensor select, and only in the following cycle does it enable the other channel. The break-before-make rule always takes priority over speed, so no path ever has both enables high at once.

Once the new channel is enabled, a programmable verification window watches the fault flag and the angle-error flag. A clean window counts as a pass. Any flag seen during the window counts as a failure: the block drops both enables and raises a sticky safe-hold request. Each accepted switchover ends with a one-cycle log record. The record holds the cause, the attempt number, the channel now in charge, the pass/fail result, and whether a further request arrived while the switch was in progress, together with that request's cause. Consecutive attempts are counted. A request that arrives when the count has reached its limit ends in safe hold instead of another switch. A clean stretch after a passed check clears the count.

Top module: `chan_switch_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, en_a is 1, en_b is 0, sens_sel is 0 (channel A), safehold_req is 0 and log_valid is 0.
- R2: en_a and en_b are never both 1. An accepted sw_req in idle or hold-off drives both enables to 0 in the next cycle, and both stay 0 for D cycles, where D is dead_ticks (0 counts as 1).
- R3: sens_sel (0 = A, 1 = B) keeps its old value during the first D-1 cycles of the break. It changes at the edge that ends the break, one cycle before the new enable rises, and it never changes while either enable is 1.
- R4: The enable of the other channel rises D+1 cycles after the edge that accepted the request.
- R5: If fault_flag and angle_err are both 0 at each of the V edges after the new enable rises (V = verify_ticks, 0 counts as 1), log_valid is 1 for exactly one cycle after the V-th of those edges, with log_pass = 1.
- R6: A 1 on fault_flag or angle_err at any edge of the verification window sets, from the next cycle, both enables to 0, safehold_req to 1 and a one-cycle log_valid with log_pass = 0.
- R7: The log record carries log_reason = the sw_reason of the accepted request (1 overstress, 2 feedback invalid, 3 angle jump, 4 power anomaly, 5 commanded drill), log_retry = the attempt number including this one, and log_chan = the channel now enabled (1 = B).
- R8: A sw_req sampled during the break or the verification window is ignored. The first such cause is latched and reported as log_late_seen = 1 with log_late_reason; otherwise log_late_seen = 0.
- R9: Each accepted switch adds one to the attempt count. A sw_req that arrives when the count equals MAX_RETRY (default 3) causes no switch and no log record. Instead, from the next cycle, safehold_req = 1 and both enables are 0.
- R10: After a pass, H consecutive edges (H = holdoff_ticks) with fault_flag and angle_err both 0 clear the attempt count to 0. A flag during the hold-off restarts the H-edge count. A request accepted during the hold-off keeps the count.
- R11: Once safehold_req is 1, it and both enables stay at their values until reset, whatever sw_req does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Switchover request, sampled each edge |
| sw_reason | input | 3 | Cause code of the request |
| fault_flag | input | 1 | Fault indication of the active channel |
| angle_err | input | 1 | Angle tracking error indication |
| dead_ticks | input | TICK_W | Break interval in cycles |
| verify_ticks | input | TICK_W | Verification window in cycles |
| holdoff_ticks | input | TICK_W | Clean cycles needed to clear the attempt count |
| en_a | output | 1 | Bridge enable, channel A |
| en_b | output | 1 | Bridge enable, channel B |
| sens_sel | output | 1 | Sensor input select, 0 = A, 1 = B |
| safehold_req | output | 1 | Sticky safe-hold request |
| log_valid | output | 1 | One-cycle log record strobe |
| log_reason | output | 3 | Cause of the logged switch |
| log_retry | output | RETRY_W | Attempt number of the logged switch |
| log_chan | output | 1 | Channel enabled by the logged switch |
| log_pass | output | 1 | Verification result, 1 = pass |
| log_late_seen | output | 1 | A request arrived during the switch |
| log_late_reason | output | 3 | Cause of the first ignored request |

## Verification
Counted from the edge that accepts a request, the enables drop after that edge. The sensor select moves after edge D, the new enable rises after edge D+1, and the log strobe follows edge D+1+V, or the first edge of the window at which a flag is seen. A refusal at the retry limit shows safe hold one edge after the request. The bench drives inputs and samples outputs on the falling edge, and it steps a whole number of edges before each check, so each check lands in the exact cycle computed for it. A model in the bench tracks the active channel and the attempt count. Randomly drawn intervals, causes, late requests and fault positions are checked against that model.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

    localparam int RSN_W = 3;

    localparam logic [RSN_W-1:0] RSN_OVERSTRESS = 3'd1;
    localparam logic [RSN_W-1:0] RSN_FEEDBACK   = 3'd2;
    localparam logic [RSN_W-1:0] RSN_ANGLE_JUMP = 3'd3;
    localparam logic [RSN_W-1:0] RSN_POWER      = 3'd4;
    localparam logic [RSN_W-1:0] RSN_DRILL      = 3'd5;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_BREAK  = 3'd1,
        ST_SWAP   = 3'd2,
        ST_VERIFY = 3'd3,
        ST_HOLD   = 3'd4,
        ST_SAFE   = 3'd5
    } arb_state_e;

    typedef struct packed {
        logic [RSN_W-1:0] reason;
        logic             chan;
        logic             pass;
        logic             late_seen;
        logic [RSN_W-1:0] late_reason;
    } log_core_t;

    function automatic logic in_flight(input arb_state_e s);
        return (s == ST_BREAK) || (s == ST_SWAP) || (s == ST_VERIFY);
    endfunction

    function automatic logic can_accept(input arb_state_e s);
        return (s == ST_RUN) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/chsw_tick_timer.sv
module chsw_tick_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [TICK_W-1:0] limit,
    output logic              done
);
    logic [TICK_W-1:0] cnt_q;

    // a limit of zero behaves as a limit of one
    assign done = (limit <= TICK_W'(1)) || (cnt_q == limit - TICK_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + TICK_W'(1);
        end
    end
endmodule

// File: rtl/chsw_late_latch.sv
module chsw_late_latch
    import chsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             req,
    input  logic [RSN_W-1:0] reason,
    input  logic             clear,
    output logic             seen,
    output logic [RSN_W-1:0] seen_reason
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen        <= 1'b0;
            seen_reason <= '0;
        end else if (busy && req && !seen) begin
            seen        <= 1'b1;
            seen_reason <= reason;
        end
    end

    p_first_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && !clear) |=> ($stable(seen_reason) && seen));
endmodule

// File: rtl/chsw_interlock.sv
module chsw_interlock (
    input  logic clk,
    input  logic rst,
    input  logic drive_d,
    input  logic chan_d,
    output logic en_a,
    output logic en_b,
    output logic sel
);
    // an enable may only rise when the other one is already low
    always_ff @(posedge clk) begin
        if (rst) begin
            en_a <= 1'b1;
            en_b <= 1'b0;
            sel  <= 1'b0;
        end else begin
            en_a <= drive_d && !chan_d && !en_b;
            en_b <= drive_d &&  chan_d && !en_a;
            sel  <= chan_d;
        end
    end

    p_never_both_r2: assert property (@(posedge clk) disable iff (rst)
        !(en_a && en_b));

    p_break_a_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_a) |-> $past(!en_b));

    p_break_b_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_b) |-> $past(!en_a));

    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en_a || en_b) |-> $stable(sel));
endmodule

// File: rtl/chan_switch_arbiter.sv
module chan_switch_arbiter
    import chsw_pkg::*;
#(
    parameter int TICK_W    = 8,
    parameter int MAX_RETRY = 3,
    localparam int RETRY_W  = $clog2(MAX_RETRY + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_req,
    input  logic [RSN_W-1:0]   sw_reason,
    input  logic               fault_flag,
    input  logic               angle_err,
    input  logic [TICK_W-1:0]  dead_ticks,
    input  logic [TICK_W-1:0]  verify_ticks,
    input  logic [TICK_W-1:0]  holdoff_ticks,
    output logic               en_a,
    output logic               en_b,
    output logic               sens_sel,
    output logic               safehold_req,
    output logic               log_valid,
    output logic [RSN_W-1:0]   log_reason,
    output logic [RETRY_W-1:0] log_retry,
    output logic               log_chan,
    output logic               log_pass,
    output logic               log_late_seen,
    output logic [RSN_W-1:0]   log_late_reason
);
    localparam logic [RETRY_W-1:0] RETRY_CAP = RETRY_W'(MAX_RETRY);

    arb_state_e         state_q, state_d;
    logic               drive_q, drive_d;
    logic               chan_q, chan_d;
    logic [RETRY_W-1:0] retry_q, retry_d;
    logic [RSN_W-1:0]   rsn_q, rsn_d;
    logic               log_fire, log_ok;
    logic               hold_restart;
    logic               tmr_clr, tmr_done;
    logic [TICK_W-1:0]  tmr_lim;
    logic               late_seen;
    logic [RSN_W-1:0]   late_rsn;
    logic               accept, refuse, bad;
    log_core_t          rec_q;
    logic [RETRY_W-1:0] rec_retry_q;
    logic               rec_valid_q;

    assign bad    = fault_flag || angle_err;
    assign accept = sw_req && can_accept(state_q) && (retry_q != RETRY_CAP);
    assign refuse = sw_req && can_accept(state_q) && (retry_q == RETRY_CAP);

    always_comb begin
        unique case (state_q)
            ST_BREAK:  tmr_lim = dead_ticks;
            ST_VERIFY: tmr_lim = verify_ticks;
            ST_HOLD:   tmr_lim = holdoff_ticks;
            default:   tmr_lim = '0;
        endcase
    end

    always_comb begin
        state_d      = state_q;
        drive_d      = drive_q;
        chan_d       = chan_q;
        retry_d      = retry_q;
        rsn_d        = rsn_q;
        log_fire     = 1'b0;
        log_ok       = 1'b0;
        hold_restart = 1'b0;
        unique case (state_q)
            ST_RUN, ST_HOLD: begin
                if (accept) begin
                    state_d = ST_BREAK;
                    drive_d = 1'b0;
                    retry_d = retry_q + RETRY_W'(1);
                    rsn_d   = sw_reason;
                end else if (refuse) begin
                    state_d = ST_SAFE;
                    drive_d = 1'b0;
                end else if (state_q == ST_HOLD) begin
                    if (bad) begin
                        hold_restart = 1'b1;
                    end else if (tmr_done) begin
                        retry_d = '0;
                        state_d = ST_RUN;
                    end
                end
            end
            ST_BREAK: begin
                if (tmr_done) begin
                    state_d = ST_SWAP;
                    chan_d  = !chan_q;
                end
            end
            ST_SWAP: begin
                state_d = ST_VERIFY;
                drive_d = 1'b1;
            end
            ST_VERIFY: begin
                if (bad) begin
                    state_d  = ST_SAFE;
                    drive_d  = 1'b0;
                    log_fire = 1'b1;
                end else if (tmr_done) begin
                    state_d  = ST_HOLD;
                    log_fire = 1'b1;
                    log_ok   = 1'b1;
                end
            end
            default: begin
                drive_d = 1'b0;
            end
        endcase
    end

    assign tmr_clr = (state_d != state_q) || hold_restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            drive_q <= 1'b1;
            chan_q  <= 1'b0;
            retry_q <= '0;
            rsn_q   <= '0;
        end else begin
            state_q <= state_d;
            drive_q <= drive_d;
            chan_q  <= chan_d;
            retry_q <= retry_d;
            rsn_q   <= rsn_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid_q <= 1'b0;
            rec_q       <= '0;
            rec_retry_q <= '0;
        end else begin
            rec_valid_q <= log_fire;
            if (log_fire) begin
                rec_q.reason      <= rsn_q;
                rec_q.chan        <= chan_q;
                rec_q.pass        <= log_ok;
                rec_q.late_seen   <= late_seen;
                rec_q.late_reason <= late_rsn;
                rec_retry_q       <= retry_q;
            end
        end
    end

    chsw_tick_timer #(.TICK_W(TICK_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (tmr_lim),
        .done  (tmr_done)
    );

    chsw_late_latch u_late (
        .clk         (clk),
        .rst         (rst),
        .busy        (in_flight(state_q)),
        .req         (sw_req),
        .reason      (sw_reason),
        .clear       (accept),
        .seen        (late_seen),
        .seen_reason (late_rsn)
    );

    chsw_interlock u_ilk (
        .clk     (clk),
        .rst     (rst),
        .drive_d (drive_d),
        .chan_d  (chan_d),
        .en_a    (en_a),
        .en_b    (en_b),
        .sel     (sens_sel)
    );

    assign safehold_req    = (state_q == ST_SAFE);
    assign log_valid       = rec_valid_q;
    assign log_reason      = rec_q.reason;
    assign log_retry       = rec_retry_q;
    assign log_chan        = rec_q.chan;
    assign log_pass        = rec_q.pass;
    assign log_late_seen   = rec_q.late_seen;
    assign log_late_reason = rec_q.late_reason;

    p_drop_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (sw_req && can_accept(state_q) && retry_q < RETRY_CAP) |=> (!en_a && !en_b));

    p_log_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        log_valid |=> !log_valid);

    p_fail_safe_r6: assert property (@(posedge clk) disable iff (rst)
        (log_valid && !log_pass) |-> (safehold_req && !en_a && !en_b));

    p_retry_bound_r9: assert property (@(posedge clk) disable iff (rst)
        retry_q <= RETRY_CAP);

    p_safe_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        safehold_req |=> (safehold_req && !en_a && !en_b));
endmodule

// File: tb/chan_switch_arbiter_tb.sv
module chan_switch_arbiter_tb;
    localparam int CLK_P     = 10;
    localparam int TICK_W    = 8;
    localparam int MAX_RETRY = 3;
    localparam int RETRY_W   = $clog2(MAX_RETRY + 1);
    localparam int HOLD_T    = 4;

    logic               clk = 1'b0;
    logic               rst;
    logic               sw_req;
    logic [2:0]         sw_reason;
    logic               fault_flag, angle_err;
    logic [TICK_W-1:0]  dead_ticks, verify_ticks, holdoff_ticks;
    logic               en_a, en_b, sens_sel, safehold_req, log_valid;
    logic [2:0]         log_reason, log_late_reason;
    logic [RETRY_W-1:0] log_retry;
    logic               log_chan, log_pass, log_late_seen;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic chan_m;
    int   retry_m;
    bit   safe_m;

    always #(CLK_P/2) clk = ~clk;

    chan_switch_arbiter #(.TICK_W(TICK_W), .MAX_RETRY(MAX_RETRY)) u_dut (
        .clk(clk), .rst(rst), .sw_req(sw_req), .sw_reason(sw_reason),
        .fault_flag(fault_flag), .angle_err(angle_err),
        .dead_ticks(dead_ticks), .verify_ticks(verify_ticks),
        .holdoff_ticks(holdoff_ticks),
        .en_a(en_a), .en_b(en_b), .sens_sel(sens_sel),
        .safehold_req(safehold_req), .log_valid(log_valid),
        .log_reason(log_reason), .log_retry(log_retry), .log_chan(log_chan),
        .log_pass(log_pass), .log_late_seen(log_late_seen),
        .log_late_reason(log_late_reason)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int en_code(input logic a, input logic b);
        return {30'd0, b, a};
    endfunction

    function automatic int want_en(input logic ch);
        return ch ? 2 : 1;
    endfunction

    task automatic do_reset();
        rst = 1'b1; sw_req = 1'b0; sw_reason = '0;
        fault_flag = 1'b0; angle_err = 1'b0;
        tick(); tick();
        rst = 1'b0;
        chan_m = 1'b0; retry_m = 0; safe_m = 0;
        chk(en_a && !en_b, "R1 enables", en_code(en_a, en_b), 1);
        chk(sens_sel == 1'b0, "R1 sens_sel", sens_sel, 0);
        chk(!safehold_req && !log_valid, "R1 safehold/log", {safehold_req, log_valid}, 0);
    endtask

    task automatic chk_fields(input logic [2:0] rsn, input logic ch,
                              input bit late, input logic [2:0] late_rsn);
        chk(log_reason == rsn, "R7 log_reason", log_reason, rsn);
        chk(int'(log_retry) == retry_m, "R7 log_retry", log_retry, retry_m);
        chk(log_chan == ch, "R7 log_chan", log_chan, ch);
        chk(log_late_seen == late, "R8 log_late_seen", log_late_seen, late);
        if (late) chk(log_late_reason == late_rsn, "R8 log_late_reason", log_late_reason, late_rsn);
    endtask

    // fail_at: 0 = clean window, k = flag at the k-th window edge
    task automatic run_switch(input logic [2:0] rsn, input int d, input int v,
                              input int fail_at, input bit use_angle,
                              input bit late, input logic [2:0] late_rsn);
        logic old_c, new_c;
        int ed, ev;
        old_c = chan_m; new_c = !chan_m;
        dead_ticks = TICK_W'(d); verify_ticks = TICK_W'(v);
        ed = eff(d); ev = eff(v);
        sw_req = 1'b1; sw_reason = rsn;
        tick();
        sw_req = 1'b0;
        if (retry_m == MAX_RETRY) begin
            chk(safehold_req, "R9 refuse safehold", safehold_req, 1);
            chk(!en_a && !en_b, "R9 refuse enables", en_code(en_a, en_b), 0);
            chk(!log_valid, "R9 refuse no log", log_valid, 0);
            safe_m = 1;
            return;
        end
        retry_m++;
        chk(!en_a && !en_b, "R2 break entry", en_code(en_a, en_b), 0);
        if (late) begin sw_req = 1'b1; sw_reason = late_rsn; end
        for (int i = 1; i <= ed; i++) begin
            tick();
            sw_req = 1'b0;
            chk(!en_a && !en_b, "R2 break hold", en_code(en_a, en_b), 0);
            if (i < ed) chk(sens_sel == old_c, "R3 sel early", sens_sel, old_c);
            else        chk(sens_sel == new_c, "R3 sel at break end", sens_sel, new_c);
        end
        tick();
        chk(en_code(en_a, en_b) == want_en(new_c), "R4 new enable", en_code(en_a, en_b), want_en(new_c));
        for (int k = 1; k <= ev; k++) begin
            if (k == fail_at) begin
                if (use_angle) angle_err = 1'b1; else fault_flag = 1'b1;
            end
            tick();
            fault_flag = 1'b0; angle_err = 1'b0;
            if (k == fail_at) begin
                chk(safehold_req, "R6 safehold", safehold_req, 1);
                chk(!en_a && !en_b, "R6 enables low", en_code(en_a, en_b), 0);
                chk(log_valid && !log_pass, "R6 fail log", {log_valid, log_pass}, 2);
                chk_fields(rsn, new_c, late, late_rsn);
                safe_m = 1;
                return;
            end
            if (k == ev) begin
                chk(log_valid && log_pass, "R5 pass log", {log_valid, log_pass}, 3);
                chk_fields(rsn, new_c, late, late_rsn);
            end else begin
                chk(!log_valid, "R5 no early log", log_valid, 0);
            end
        end
        tick();
        chk(!log_valid, "R5 single pulse", log_valid, 0);
        chan_m = new_c;
    endtask

    task automatic safe_probe();
        sw_req = 1'b1; sw_reason = 3'd5;
        tick(); tick();
        sw_req = 1'b0;
        chk(safehold_req && !en_a && !en_b, "R11 safe sticky",
            {safehold_req, en_a, en_b}, 4);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        holdoff_ticks = TICK_W'(HOLD_T);
        dead_ticks = 8'd2; verify_ticks = 8'd2;
        do_reset();

        // directed: A->B with a late request, then back with dead interval 0
        run_switch(3'd1, 3, 3, 0, 0, 1, 3'd4);
        run_switch(3'd2, 0, 2, 0, 0, 0, 3'd0);
        // retry count keeps growing, third switch then refusal
        run_switch(3'd3, 1, 1, 0, 0, 0, 3'd0);
        run_switch(3'd5, 2, 2, 0, 0, 0, 3'd0);
        if (safe_m) safe_probe();
        do_reset();

        // R10: clean hold-off clears the count
        run_switch(3'd4, 2, 2, 0, 0, 0, 3'd0);
        for (int i = 0; i < HOLD_T; i++) tick();
        retry_m = 0;
        run_switch(3'd1, 2, 2, 0, 0, 0, 3'd0);   // logs retry 1 (R10)
        // R10: flag in hold-off restarts the count, retry not cleared
        for (int i = 0; i < HOLD_T - 2; i++) tick();
        angle_err = 1'b1; tick(); angle_err = 1'b0;
        tick();
        run_switch(3'd2, 1, 1, 0, 0, 0, 3'd0);   // logs retry 2 (R10)

        // R6 with angle error in the window
        run_switch(3'd3, 2, 3, 2, 1, 0, 3'd0);
        safe_probe();
        do_reset();

        // random mix
        for (int it = 0; it < 60; it++) begin
            int d, v, fa, gap;
            bit late;
            logic [2:0] rsn, lr;
            d   = $urandom_range(0, 4);
            v   = $urandom_range(0, 4);
            rsn = 3'($urandom_range(1, 5));
            lr  = 3'($urandom_range(1, 5));
            late = ($urandom_range(0, 1) == 1);
            fa  = ($urandom_range(0, 7) == 0) ? $urandom_range(1, eff(v)) : 0;
            run_switch(rsn, d, v, fa, $urandom_range(0, 1) == 1, late, lr);
            if (safe_m) begin
                safe_probe();
                do_reset();
            end else begin
                gap = $urandom_range(0, 2);
                if (gap == 0) begin
                    for (int i = 0; i < HOLD_T; i++) tick();
                    retry_m = 0;
                end
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule